// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block synchronizes a fixed group of agents at a rendezvous point. An agent signals that it has reached the barrier with a one-cycle pulse on its arrive line. It then waits until every member of the group has done the same. One shared counter tracks how many agents are waiting, and one shared release flag gates all waiting agents. The counter is updated in a single clocked step that takes in every arrival of the cycle, so it stays consistent when several agents arrive together.

Each agent has a private sense bit. Accepting an arrival inverts it. An agent is waiting while its sense differs from the shared flag. When the arrivals of a cycle fill the group, the counter returns to zero and the flag takes the new sense value. That single write frees every waiting agent. Because each episode flips the polarity, an agent can enter the next barrier in the cycle after it is released. It then neither holds back nor frees the agents that are still leaving the previous episode, and no second counter is needed.

Top module: `barrier_unit`

## Requirements
- R1: After an accepted arrival that does not complete the episode, that agent's `release_o` bit is low from the next cycle until the episode completes.
- R2: The arrival counter grows by the number of arrivals accepted in a cycle, including several in the same cycle. It always equals the number of waiting agents and never reaches N_AGENTS while agents are still waiting.
- R3: When the accepted arrivals of a cycle bring the count to N_AGENTS, all `release_o` bits are high and the counter is zero in the next cycle.
- R4: The shared flag changes only in the cycle after a completing arrival. Each accepted arrival inverts that agent's sense bit, so back-to-back episodes, including all agents arriving together in consecutive cycles, each complete correctly.
- R5: An agent that arrives again in the cycle right after its release starts a new episode from a count of one. Agents that do not arrive keep `release_o` high.
- R6: An arrive pulse from an agent whose `release_o` is low is ignored. It neither advances the count nor changes that agent's state.
- R7: While `rst_ni` is low and in the first cycle after it, the counter is zero, the flag and all sense bits are zero, and every `release_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_AGENTS | One pulse per agent on reaching the barrier; bit i belongs to agent i |
| release_o | output | N_AGENTS | High while agent i is not waiting at the barrier |

## Verification
Single arrivals spread over separate cycles show that a partial count holds agents back and that only the final arrival frees them. Paired arrivals, and all agents arriving in one cycle, show that the counter adds several arrivals at once and completes in that same cycle rather than one arrival per cycle. Repeated pulses from agents already waiting show that the count is not inflated, and an immediate re-arrival after release shows that the polarity flip keeps episodes apart. A long random run with sparse, overlapping pulses is compared every cycle with a bench model of the waiting set.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  localparam int unsigned MAX_AGENTS = 16;

  // number of set bits in a vector of up to MAX_AGENTS agents
  function automatic int unsigned ones16(input logic [MAX_AGENTS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_AGENTS; i++) begin
      n = n + 32'(v[i]);
    end
    return n;
  endfunction

  // the group is full when the waiting agents plus this cycle's arrivals cover it
  function automatic logic group_full(input int unsigned waiting,
                                      input int unsigned arriving,
                                      input int unsigned group);
    return (waiting + arriving) == group;
  endfunction

  // counter value after one cycle of arrivals
  function automatic int unsigned next_fill(input int unsigned waiting,
                                            input int unsigned arriving,
                                            input int unsigned group);
    if (group_full(waiting, arriving, group)) begin
      return 0;
    end
    return waiting + arriving;
  endfunction

endpackage

// File: rtl/bar_accept.sv
module bar_accept #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned CNT_W = $clog2(N_AGENTS + 1)
) (
  input  logic [N_AGENTS-1:0] arrive_i,
  input  logic [N_AGENTS-1:0] released_i,
  output logic [N_AGENTS-1:0] accept_o,
  output logic [N_AGENTS-1:0] reject_o,
  output logic [CNT_W-1:0]    accept_cnt_o
);
  import barrier_pkg::*;

  logic [MAX_AGENTS-1:0] accept_wide;

  // only agents not already waiting may enter the episode
  assign accept_o = arrive_i & released_i;
  assign reject_o = arrive_i & ~released_i;

  always_comb begin
    accept_wide = '0;
    accept_wide[N_AGENTS-1:0] = accept_o;
  end

  assign accept_cnt_o = CNT_W'(ones16(accept_wide));

endmodule

// File: rtl/bar_fill_counter.sv
module bar_fill_counter #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned CNT_W = $clog2(N_AGENTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] accept_cnt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             complete_o
);
  import barrier_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  assign complete_o = group_full(32'(count_q), 32'(accept_cnt_i), N_AGENTS);
  assign count_d    = CNT_W'(next_fill(32'(count_q), 32'(accept_cnt_i), N_AGENTS));

  // single clocked update that takes every arrival of the cycle at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/bar_sense_bank.sv
module bar_sense_bank #(
  parameter int unsigned N_AGENTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] accept_i,
  input  logic                complete_i,
  output logic [N_AGENTS-1:0] sense_o,
  output logic                flag_o,
  output logic [N_AGENTS-1:0] released_o
);

  logic flag_q;

  // shared release flag: takes the new polarity once per episode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (complete_i) begin
      flag_q <= ~flag_q;
    end
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    logic sense_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sense_q <= 1'b0;
      end else if (accept_i[g]) begin
        sense_q <= ~sense_q;
      end
    end

    assign sense_o[g]    = sense_q;
    assign released_o[g] = (sense_q == flag_q);
  end

endmodule

// File: rtl/barrier_unit.sv
module barrier_unit #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned CNT_W = $clog2(N_AGENTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] arrive_i,
  output logic [N_AGENTS-1:0] release_o
);

  if (N_AGENTS < 2 || N_AGENTS > 16) begin : g_bad_group
    $error("barrier_unit: N_AGENTS must lie in 2..16");
  end

  // named internal events, observed by the bound checker
  logic [N_AGENTS-1:0] accept_w;
  logic [N_AGENTS-1:0] reject_w;
  logic [CNT_W-1:0]    accept_cnt_w;
  logic [CNT_W-1:0]    count_w;
  logic                complete_w;
  logic [N_AGENTS-1:0] sense_w;
  logic                flag_w;
  logic [N_AGENTS-1:0] released_w;

  bar_accept #(.N_AGENTS(N_AGENTS)) u_accept (
    .arrive_i     (arrive_i),
    .released_i   (released_w),
    .accept_o     (accept_w),
    .reject_o     (reject_w),
    .accept_cnt_o (accept_cnt_w)
  );

  bar_fill_counter #(.N_AGENTS(N_AGENTS)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_cnt_i (accept_cnt_w),
    .count_o      (count_w),
    .complete_o   (complete_w)
  );

  bar_sense_bank #(.N_AGENTS(N_AGENTS)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept_w),
    .complete_i (complete_w),
    .sense_o    (sense_w),
    .flag_o     (flag_w),
    .released_o (released_w)
  );

  assign release_o = released_w;

endmodule

// File: rtl/barrier_unit_chk.sv
module barrier_unit_chk #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned CNT_W = $clog2(N_AGENTS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_AGENTS-1:0] arrive_i,
  input logic [N_AGENTS-1:0] release_o,
  input logic [N_AGENTS-1:0] accept_i,
  input logic [CNT_W-1:0]    count_i,
  input logic                complete_i,
  input logic [N_AGENTS-1:0] sense_i,
  input logic                flag_i
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(N_AGENTS);

  AST_COUNT_IS_WAITERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == CNT_W'($countones(sense_i ^ {N_AGENTS{flag_i}}))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i < FULL); // R2

  AST_FILL_RELEASES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_i |=> (&release_o && count_i == '0)); // R3

  AST_FLAG_ONLY_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i != $past(flag_i)) |-> $past(complete_i)); // R4

  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    !rst_ni |=> (count_i == '0 && !flag_i && sense_i == '0 && &release_o)); // R7

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent_chk
    AST_ARRIVER_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i[g] && !complete_i) |=> !release_o[g]); // R1

    AST_OTHERS_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_o[g] && !arrive_i[g] && !complete_i) |=> release_o[g]); // R5

    AST_WAITER_PULSE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arrive_i[g] && !release_o[g] && !complete_i) |=> (!release_o[g] && $stable(sense_i[g]))); // R6
  end

endmodule

bind barrier_unit barrier_unit_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arrive_i   (arrive_i),
  .release_o  (release_o),
  .accept_i   (accept_w),
  .count_i    (count_w),
  .complete_i (complete_w),
  .sense_i    (sense_w),
  .flag_i     (flag_w)
);

// File: tb/barrier_unit_test.sv
`timescale 1ns/1ps
module barrier_unit_test;

  localparam int unsigned N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] arrive;
  logic [N-1:0] release_o;

  int checks;
  int failures;
  bit done;

  // bench model: set of waiting agents and count
  logic [N-1:0] m_wait;
  int           m_cnt;
  bit           m_filled;

  barrier_unit #(.N_AGENTS(N)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .arrive_i  (arrive),
    .release_o (release_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int bits_set(input logic [N-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_step(input logic [N-1:0] arr);
    logic [N-1:0] acc;
    acc = arr & ~m_wait;
    m_filled = (m_cnt + bits_set(acc)) == N;
    if (m_filled) begin
      m_wait = '0;
      m_cnt  = 0;
    end else begin
      m_wait = m_wait | acc;
      m_cnt  = m_cnt + bits_set(acc);
    end
  endtask

  task automatic check_rel(input string tag);
    checks++;
    if (release_o !== ~m_wait) begin
      failures++;
      $display("FAIL %s release_o actual=%b expected=%b", tag, release_o, ~m_wait);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic [N-1:0] arr, input string tag);
    arrive = arr;
    @(posedge clk);
    model_step(arr);
    @(negedge clk);
    check_rel(tag);
  endtask

  task automatic do_reset();
    arrive = '0;
    rst_n  = 1'b0;
    m_wait = '0;
    m_cnt  = 0;
    repeat (2) @(negedge clk);
    check_rel("R7");
    rst_n = 1'b1;
    @(negedge clk);
    check_rel("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    arrive = '0; rst_n = 1'b0;
    m_wait = '0; m_cnt = 0; m_filled = 0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R1: single arrivals hold agents back; last one frees everyone (R3)
    step(4'b0001, "R1");
    step(4'b0000, "R1");
    step(4'b0100, "R1");
    step(4'b0010, "R1");
    step(4'b1000, "R3");
    checks++;
    if (release_o !== 4'b1111) begin
      failures++;
      $display("FAIL R3 all released actual=%b expected=%b", release_o, 4'b1111);
    end

    // R6: repeated pulses from a waiting agent do not count
    step(4'b0001, "R6");
    step(4'b0001, "R6");
    step(4'b0001, "R6");
    step(4'b0011, "R6");
    step(4'b0111, "R6");
    checks++;
    if (release_o !== 4'b1000) begin
      failures++;
      $display("FAIL R6 three waiting actual=%b expected=%b", release_o, 4'b1000);
    end
    step(4'b1000, "R3");

    // R2: paired arrivals in one cycle, completion on the second pair
    step(4'b0101, "R2");
    step(4'b1010, "R3");
    // R3: all agents in one cycle
    step(4'b1111, "R3");
    // R4: back-to-back full episodes, polarity flips each time
    step(4'b1111, "R4");
    step(4'b1111, "R4");
    step(4'b1111, "R4");

    // R5: early re-entry right after release
    step(4'b0011, "R5");
    step(4'b1100, "R3");
    step(4'b0001, "R5");
    checks++;
    if (release_o !== 4'b1110) begin
      failures++;
      $display("FAIL R5 re-entry actual=%b expected=%b", release_o, 4'b1110);
    end
    step(4'b0000, "R5");
    step(4'b0110, "R5");
    step(4'b1000, "R3");

    // R7: reset in the middle of an episode
    step(4'b0011, "R1");
    do_reset();

    // random mix of sparse overlapping arrivals
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r;
      r = N'($urandom) & N'($urandom);
      step(r, m_filled ? "R3" : "R2");
    end

    step(4'b0000, "R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule